// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier with Shadowed Output Forcing

This block is the output stage that sits behind a PWM time base. On every cycle where the time base asserts its tick enable, it looks at four counter events:

- the counter at zero;
- the counter at its period;
- the counter equal to compare value A while counting up;
- the counter equal to compare value B while counting up.

Each channel has its own action word, which assigns a 2-bit action to each of these events. The event logic keeps one state bit per channel.

A software force can override each output with a fixed level. The force input word is the shadow copy. It moves into the active force register at a reload point chosen by a 2-bit select: on zero, on period, on either, or on every tick. While a force is active, the event state keeps tracking events underneath it. When the force is released, the pin shows the waveform as if the force had never been applied.

A typical use is edge-aligned PWM in up-count mode. For normal polarity, program "high" on zero and period and "low" on the channel's compare-up match. For inverted polarity, program the opposite levels. Dead-band, chopping and trip handling live elsewhere.

Top module: `pwm_aq_force`

## Requirements
- R1: After a synchronous active-low reset, both outputs are low, both event states are low and both active force codes are 00.
- R2: In each 10-bit action word, the zero event uses bits 1:0, period uses bits 3:2, compare-A-up uses bits 5:4 and compare-B-up uses bits 9:8. Bits 7:6 must be 00. The action codes are: 00 no change, 01 low, 10 high, 11 toggle.
- R3: A compare event counts only when the count equals that compare value, the direction input is 1 (up) and tick is 1. An equal count while counting down causes no action.
- R4: When several events with non-00 actions coincide on one tick, the priority is compare-B over compare-A over period over zero.
- R5: On a cycle with tick at 0, neither event state nor any output changes, whatever the other inputs do.
- R6: In force_word, output A's force code is bits 1:0 and output B's is bits 3:2. Code 01 holds the pin low and 10 holds it high. Codes 00 and 11 let the event state drive the pin.
- R7: The reload select chooses when the active force code is loaded from force_word on a tick: 00 at zero, 01 at period, 10 at zero or period. At other times the active code holds.
- R8: With reload select 11, force_word is loaded on every tick and governs the pins from the cycle after that tick edge.
- R9: Event state keeps updating while a force is active. Releasing the force shows the current event state.
- R10: With normal polarity programming (high on zero and period, low on own compare-up), each output is high from zero until its compare match and low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base tick enable; events act only when 1 |
| tb_cnt | input | 16 | Time-base count value |
| tb_up | input | 1 | Count direction, 1 = counting up |
| tb_zero | input | 1 | Counter-at-zero event |
| tb_period | input | 1 | Counter-at-period event |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_a | input | 10 | Action word for output A |
| act_b | input | 10 | Action word for output B |
| force_word | input | 4 | Shadow force codes (A at 1:0, B at 3:2) |
| reload_sel | input | 2 | Force reload point select |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The event logic is driven with these patterns, and each separates a different fault:

- **Normal-polarity up-count with a tick on every cycle.** This separates compare A from compare B and checks the duty timing.
- **Inverted programming and toggle actions with a tick every third cycle.** This shows that action codes are decoded correctly and that the gaps between ticks are ignored.
- **Compare values placed on zero and on period.** This exposes any error in the priority order.
- **An up-down count.** This tells matches counting up apart from equal counts on the way down.

The forcing path is exercised with each reload select. The force is then released mid-waveform, which shows whether the event state kept tracking underneath the force.

// File: rtl/pwm_aq_pkg.sv
// Shared action encoding and per-event resolution helpers for the PWM
// action qualifier. Assumes 2-bit action fields as listed in the brief.
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        AQ_NONE   = 2'b00,
        AQ_LOW    = 2'b01,
        AQ_HIGH   = 2'b10,
        AQ_TOGGLE = 2'b11
    } aq_act_e;

    // Choose the winning action: compare B, then compare A, then period, then zero.
    function automatic aq_act_e pick_action(
        input aq_act_e on_zero, input aq_act_e on_prd,
        input aq_act_e on_ca,   input aq_act_e on_cb,
        input logic    ev_zero, input logic    ev_prd,
        input logic    ev_ca,   input logic    ev_cb);
        aq_act_e w;
        w = AQ_NONE;
        if (ev_zero && on_zero != AQ_NONE) w = on_zero;
        if (ev_prd  && on_prd  != AQ_NONE) w = on_prd;
        if (ev_ca   && on_ca   != AQ_NONE) w = on_ca;
        if (ev_cb   && on_cb   != AQ_NONE) w = on_cb;
        return w;
    endfunction

    // Apply one action to the current level.
    function automatic logic apply_action(input aq_act_e a, input logic cur);
        case (a)
            AQ_LOW:    return 1'b0;
            AQ_HIGH:   return 1'b1;
            AQ_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_aq_force_reg.sv
// Active force register bank. force_word is treated as the shadow copy;
// it is copied into the active register on a tick at the reload point
// chosen by reload_sel. Assumes tick qualifies every time-base event.
module pwm_aq_force_reg #(
    parameter int NCH = 2,
    localparam int FW = 2 * NCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          at_zero,
    input  logic          at_period,
    input  logic [1:0]    reload_sel,
    input  logic [FW-1:0] force_word,
    output logic [FW-1:0] force_act
);

    logic          load_pt;
    logic [FW-1:0] act_q;

    // Decode the reload point from the select code.
    always_comb begin
        case (reload_sel)
            2'b00:   load_pt = at_zero;
            2'b01:   load_pt = at_period;
            2'b10:   load_pt = at_zero | at_period;
            default: load_pt = 1'b1;
        endcase
    end

    // Move shadow force codes into the active register at the reload point.
    always_ff @(posedge clk) begin
        if (!rst_n)                act_q <= '0;
        else if (tick && load_pt)  act_q <= force_word;
    end

    assign force_act = act_q;

    AST_FORCE_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(act_q)); // R7
    AST_ZERO_MODE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload_sel == 2'b00 && !at_zero) |=> $stable(act_q)); // R7
    AST_IMMEDIATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload_sel == 2'b11) |=> act_q == $past(force_word)); // R8

endmodule

// File: rtl/pwm_aq_channel.sv
// One output channel: resolves coincident events by fixed priority,
// updates its event state on a tick, and lets an active force code
// override the pin while the state keeps tracking underneath.
module pwm_aq_channel
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ev_zero,
    input  logic       ev_prd,
    input  logic       ev_ca,
    input  logic       ev_cb,
    input  aq_act_e    on_zero,
    input  aq_act_e    on_prd,
    input  aq_act_e    on_ca,
    input  aq_act_e    on_cb,
    input  logic [1:0] frc,
    output logic       pwm
);

    aq_act_e win;
    logic    ev_q;

    // Resolve the winning action among the events present this cycle.
    always_comb win = pick_action(on_zero, on_prd, on_ca, on_cb,
                                  ev_zero, ev_prd, ev_ca, ev_cb);

    // Event state updates only on a tick, independent of forcing.
    always_ff @(posedge clk) begin
        if (!rst_n)     ev_q <= 1'b0;
        else if (tick)  ev_q <= apply_action(win, ev_q);
    end

    // Output mux: an active force level wins over the event state.
    always_comb begin
        case (frc)
            2'b01:   pwm = 1'b0;
            2'b10:   pwm = 1'b1;
            default: pwm = ev_q;
        endcase
    end

    AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ev_q)); // R5
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && win == AQ_TOGGLE) |=> ev_q != $past(ev_q)); // R2
    AST_FORCE_LOW_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        frc == 2'b01 |-> !pwm); // R6

endmodule

// File: rtl/pwm_aq_force.sv
// Top of the two-channel action qualifier. Derives compare-up events from
// the time-base inputs, splits the action words into typed fields and
// builds one channel per output. Assumes action word bits 7:6 are zero.
module pwm_aq_force
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] tb_cnt,
    input  logic             tb_up,
    input  logic             tb_zero,
    input  logic             tb_period,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [9:0]       act_a,
    input  logic [9:0]       act_b,
    input  logic [3:0]       force_word,
    input  logic [1:0]       reload_sel,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int NCH = 2;

    logic             hit_ca, hit_cb;
    logic [9:0]       act_w [NCH];
    logic [2*NCH-1:0] force_act;
    logic [NCH-1:0]   pin;

    // Compare events count only while the counter runs upward.
    always_comb begin
        hit_ca = tb_up && (tb_cnt == cmp_a);
        hit_cb = tb_up && (tb_cnt == cmp_b);
    end

    assign act_w[0] = act_a;
    assign act_w[1] = act_b;

    pwm_aq_force_reg #(.NCH(NCH)) u_force (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .at_zero    (tb_zero),
        .at_period  (tb_period),
        .reload_sel (reload_sel),
        .force_word (force_word),
        .force_act  (force_act)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_aq_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .ev_zero (tb_zero),
            .ev_prd  (tb_period),
            .ev_ca   (hit_ca),
            .ev_cb   (hit_cb),
            .on_zero (aq_act_e'(act_w[g][1:0])),
            .on_prd  (aq_act_e'(act_w[g][3:2])),
            .on_ca   (aq_act_e'(act_w[g][5:4])),
            .on_cb   (aq_act_e'(act_w[g][9:8])),
            .frc     (force_act[2*g +: 2]),
            .pwm     (pin[g])
        );
    end

    assign pwm_a = pin[0];
    assign pwm_b = pin[1];

    AST_RSVD_BITS_A: assert property (@(posedge clk) disable iff (!rst_n)
        act_a[7:6] == 2'b00); // R2
    AST_RSVD_BITS_B: assert property (@(posedge clk) disable iff (!rst_n)
        act_b[7:6] == 2'b00); // R2
    AST_PINS_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b))); // R5

endmodule

// File: tb/pwm_aq_force_test.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the pins on every falling edge.
module pwm_aq_force_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] tb_cnt = '0;
    logic        tb_up = 1'b1;
    logic        tb_zero = 1'b0;
    logic        tb_period = 1'b0;
    logic [15:0] cmp_a = '0;
    logic [15:0] cmp_b = '0;
    logic [9:0]  act_a = '0;
    logic [9:0]  act_b = '0;
    logic [3:0]  force_word = '0;
    logic [1:0]  reload_sel = '0;
    logic        pwm_a, pwm_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state.
    int m_ea = 0, m_eb = 0, m_fa = 0, m_fb = 0;
    // Time-base generator state.
    int c = 0;
    int dir = 1;
    int phase = 0;

    always #5 clk = ~clk;

    pwm_aq_force uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tb_cnt(tb_cnt),
        .tb_up(tb_up), .tb_zero(tb_zero), .tb_period(tb_period),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
        .force_word(force_word), .reload_sel(reload_sel),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic int resolve(int aw, bit z, bit p, bit ca, bit cb, int cur);
        int code;
        int fld [4];
        bit hit [4];
        code = 0;
        fld[0] = aw & 3;        hit[0] = z;
        fld[1] = (aw >> 2) & 3; hit[1] = p;
        fld[2] = (aw >> 4) & 3; hit[2] = ca;
        fld[3] = (aw >> 8) & 3; hit[3] = cb;
        for (int k = 3; k >= 0; k--)
            if (code == 0 && hit[k] && fld[k] != 0) code = fld[k];
        if (code == 1) return 0;
        if (code == 2) return 1;
        if (code == 3) return 1 - cur;
        return cur;
    endfunction

    function automatic int pin_of(int f, int e);
        if (f == 1) return 0;
        if (f == 2) return 1;
        return e;
    endfunction

    // Reference model: advance expected state on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ea = 0; m_eb = 0; m_fa = 0; m_fb = 0;
        end else if (tick) begin
            bit ca, cb, ld;
            ca = tb_up && (tb_cnt == cmp_a);
            cb = tb_up && (tb_cnt == cmp_b);
            m_ea = resolve(int'(act_a), tb_zero, tb_period, ca, cb, m_ea);
            m_eb = resolve(int'(act_b), tb_zero, tb_period, ca, cb, m_eb);
            case (reload_sel)
                2'd0: ld = tb_zero;
                2'd1: ld = tb_period;
                2'd2: ld = tb_zero || tb_period;
                default: ld = 1'b1;
            endcase
            if (ld) begin
                m_fa = int'(force_word[1:0]);
                m_fb = int'(force_word[3:2]);
            end
        end
    end

    task automatic chk(string tag);
        int xa, xb;
        xa = pin_of(m_fa, m_ea);
        xb = pin_of(m_fb, m_eb);
        n_chk += 2;
        if (pwm_a !== xa[0]) begin
            n_fail++;
            $display("FAIL %s pwm_a actual %0b expected %0d at %0t", tag, pwm_a, xa, $time);
        end
        if (pwm_b !== xb[0]) begin
            n_fail++;
            $display("FAIL %s pwm_b actual %0b expected %0d at %0t", tag, pwm_b, xb, $time);
        end
    endtask

    // Run n cycles of time base; compare on each falling edge, then drive.
    task automatic run_tb(int n, int prd, int div, bit updown, string tag);
        for (int i = 0; i < n; i++) begin
            bit t;
            @(negedge clk);
            chk(tag);
            if (c > prd) c = 0;
            t = (phase % div) == 0;
            phase++;
            tick      = t;
            tb_cnt    = 16'(c);
            tb_up     = updown ? dir[0] : 1'b1;
            tb_zero   = (c == 0);
            tb_period = (c == prd);
            if (t) begin
                if (!updown) begin
                    c = (c >= prd) ? 0 : c + 1;
                end else if (dir == 1) begin
                    if (c >= prd) begin dir = 0; c = c - 1; end
                    else c = c + 1;
                end else begin
                    if (c == 0) begin dir = 1; c = c + 1; end
                    else c = c - 1;
                end
            end
        end
    endtask

    initial begin
        // R1: reset state while rst_n is low and just after release.
        act_a = 10'h1A; act_b = 10'h10A; force_word = 4'h6;
        run_tb(4, 9, 1, 0, "R1");
        @(negedge clk);
        chk("R1");
        act_a = '0; act_b = '0; force_word = '0;
        rst_n = 1'b1;
        run_tb(6, 9, 1, 0, "R1");

        // R10: normal polarity, distinct duty per channel.
        cmp_a = 16'd3; cmp_b = 16'd6;
        act_a = 10'h01A; act_b = 10'h10A;
        run_tb(40, 9, 1, 0, "R10");

        // R2: inverted levels on A, toggle-on-zero on B, gaps between ticks (R5).
        act_a = 10'h025; act_b = 10'h003;
        run_tb(60, 7, 3, 0, "R2");
        run_tb(30, 7, 7, 0, "R5");

        // R4: coincident events (compare A on zero, compare B on period).
        cmp_a = 16'd0; cmp_b = 16'd5;
        act_a = 10'h012; act_b = 10'h138;
        run_tb(40, 5, 1, 0, "R4");

        // R3: up-down count, toggles only on the upward pass.
        c = 0; dir = 1;
        cmp_a = 16'd4; cmp_b = 16'd2;
        act_a = 10'h030; act_b = 10'h302;
        run_tb(60, 8, 1, 1, "R3");
        c = 0; dir = 1;

        // R6 / R7: forcing with each shadowed reload point.
        cmp_a = 16'd3; cmp_b = 16'd6;
        act_a = 10'h01A; act_b = 10'h10A;
        reload_sel = 2'b00; force_word = 4'h6;
        run_tb(25, 9, 1, 0, "R7");
        reload_sel = 2'b01; force_word = 4'h9;
        run_tb(25, 9, 1, 0, "R7");
        reload_sel = 2'b10; force_word = 4'hF;
        run_tb(25, 9, 1, 0, "R6");
        force_word = 4'h2;
        run_tb(25, 9, 1, 0, "R6");

        // R9: release the force mid-waveform; event state tracked underneath.
        force_word = 4'h0;
        run_tb(30, 9, 2, 0, "R9");

        // R8: immediate reload, changing the force word between ticks.
        reload_sel = 2'b11;
        force_word = 4'h1;
        run_tb(9, 9, 4, 0, "R8");
        force_word = 4'h8;
        run_tb(9, 9, 4, 0, "R8");
        force_word = 4'h0;
        run_tb(20, 9, 4, 0, "R8");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule